// File: doc/BRIEF.md
# List-Walking Scatter-Gather DMA Engine

This engine copies data between a processing element's local scratchpad and a system memory port. Software offers one command and is then free to do other work. The engine makes every read and write on both memories and raises a sticky completion interrupt when the whole command is done. The command's direction is either get (remote to local) or put (local to remote).

A simple command moves one contiguous block. The block is given by a local address, a remote address and a byte count. A list command moves many blocks under one issue and one completion. It points at a run of descriptors held in local memory. Each descriptor names a remote address and a size. Local data for the whole list is packed back to back, starting at the command's local address. Both memories are word-wide request/response ports, and the word is 16 bytes. Illegal commands are refused with a sticky error bit instead of being started. These are oversize blocks, misaligned fields and list lengths out of range.

Top module: `sg_dma_engine`

## Requirements
- R1: A simple get with a size of N bytes (N a multiple of 16) copies N/16 words from remote memory, starting at the remote address, to local memory, starting at the local address. It makes exactly one remote read and one local write per word, and leaves the word after the block untouched.
- R2: A simple put copies N/16 words from local memory to remote memory in the same way. It makes one local read and one remote write per word.
- R3: A simple command whose size is above 16384 bytes is refused: the error flag is set, busy never rises, there is no bus request and no interrupt. A size of exactly 16384 is accepted and moves 1024 words.
- R4: A command whose local address, remote address or size has any of bits [3:0] set is refused like R3. For a list command, the same applies to the local address and to the descriptor pointer.
- R5: A list command carries its element count on the size input. A count below 2 or above 2048 is refused like R3, and no data moves. Counts of 2 and 2048 are accepted.
- R6: List element i is the 16-byte local word at descriptor pointer + 16*i. Its remote address is bits [31:0] and its byte size is bits [63:32]. Elements are processed in order, each exactly like a simple command. The local address runs on from one element to the next. A list costs one local descriptor read per element, on top of the data traffic.
- R7: An element of size zero causes no data access: only its descriptor is read, and the walk goes on. A simple command of size zero completes with an interrupt and no bus request at all.
- R8: An element whose size is above 16384, or whose remote address or size has any of bits [3:0] set, stops the walk. The error flag is set, busy falls, and no interrupt is raised. Elements before it have already been moved.
- R9: Busy is high from the cycle after acceptance until completion or abort. While busy, cmd_ready is low, and a command offered then is not taken.
- R10: The interrupt is set only after the final write response. It stays set until stat_clr[0] is pulsed. The error flag stays set until stat_clr[1] is pulsed.
- R11: At most one memory request is outstanding at a time. A request that is not accepted is held with its address unchanged. No request is made while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle (engine idle) |
| cmd_put | input | 1 | 1 = put (local to remote), 0 = get |
| cmd_list | input | 1 | 1 = list command |
| cmd_laddr | input | LA_W | Local start address |
| cmd_raddr | input | RA_W | Remote start address (simple command) |
| cmd_size | input | CSZ_W | Byte count (simple) or element count (list) |
| cmd_lptr | input | LA_W | Descriptor list pointer in local memory |
| stat_clr | input | 2 | Write-one-to-clear: bit 0 interrupt, bit 1 error |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Sticky completion interrupt |
| err | output | 1 | Sticky illegal-command / bad-element flag |
| l_req_valid | output | 1 | Local request valid |
| l_req_ready | input | 1 | Local request accepted |
| l_req_we | output | 1 | Local request is a write |
| l_req_addr | output | LA_W | Local byte address |
| l_req_wdata | output | DATA_W | Local write data |
| l_rsp_valid | input | 1 | Local read data or write acknowledge |
| l_rsp_rdata | input | DATA_W | Local read data |
| r_req_valid | output | 1 | Remote request valid |
| r_req_ready | input | 1 | Remote request accepted |
| r_req_we | output | 1 | Remote request is a write |
| r_req_addr | output | RA_W | Remote byte address |
| r_req_wdata | output | DATA_W | Remote write data |
| r_rsp_valid | input | 1 | Remote read data or write acknowledge |
| r_rsp_rdata | input | DATA_W | Remote read data |

## Verification
Simple commands are swept in both directions over sizes from zero to 21 words at shifting addresses. Each word carries a pattern unique to its index, so a wrong direction, a shifted address or an off-by-one length shows up as a mismatch, an overwritten sentinel or a wrong request count. List runs mix zero-size and data elements, including the minimum and maximum counts. The per-port request totals separate the descriptor reads from the data beats and show that empty elements are skipped. Refusals are tried on each field in turn, on both sides of each limit, and an element fault in mid-list shows that the abort keeps the earlier data and raises no interrupt.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_DESC,
    S_READ,
    S_WRITE,
    S_NEXT,
    S_DONE
  } walk_state_e;

  localparam int DESC_SIZE_W = 32;

  function automatic logic is_aligned(input logic [31:0] v, input int sh);
    logic [31:0] mask;
    mask = (32'd1 << sh) - 32'd1;
    return (v & mask) == 32'd0;
  endfunction

  function automatic logic size_fits(input logic [31:0] sz, input int max_b);
    return sz <= 32'(max_b);
  endfunction

  function automatic logic list_len_ok(input logic [31:0] n, input int lo, input int hi);
    return (n >= 32'(lo)) && (n <= 32'(hi));
  endfunction

  function automatic logic elem_ok(input logic [31:0] ra, input logic [31:0] sz,
                                   input int sh, input int max_b);
    return is_aligned(ra, sh) && is_aligned(sz, sh) && size_fits(sz, max_b);
  endfunction

endpackage

// File: rtl/sgd_cmd_check.sv
module sgd_cmd_check
  import sgd_pkg::*;
#(
  parameter int LA_W     = 16,
  parameter int RA_W     = 32,
  parameter int CSZ_W    = 20,
  parameter int BEAT_SH  = 4,
  parameter int MAX_BLK  = 16384,
  parameter int MIN_LIST = 2,
  parameter int MAX_LIST = 2048
) (
  input  logic             is_list,
  input  logic [LA_W-1:0]  laddr,
  input  logic [RA_W-1:0]  raddr,
  input  logic [CSZ_W-1:0] size,
  input  logic [LA_W-1:0]  lptr,
  output logic             bad
);

  logic lad_ok;
  assign lad_ok = is_aligned(32'(laddr), BEAT_SH);

  always_comb begin
    if (is_list) begin
      bad = !lad_ok || !is_aligned(32'(lptr), BEAT_SH) ||
            !list_len_ok(32'(size), MIN_LIST, MAX_LIST);
    end else begin
      bad = !lad_ok || !elem_ok(32'(raddr), 32'(size), BEAT_SH, MAX_BLK);
    end
  end

endmodule

// File: rtl/sgd_port_route.sv
module sgd_port_route #(
  parameter int LA_W   = 16,
  parameter int RA_W   = 32,
  parameter int DATA_W = 128
) (
  input  logic              rq_valid,
  input  logic              rq_local,
  input  logic              rq_we,
  input  logic [RA_W-1:0]   rq_addr,
  input  logic [DATA_W-1:0] rq_wdata,
  output logic              rq_ready,
  output logic              rs_valid,
  output logic [DATA_W-1:0] rs_data,
  output logic              l_req_valid,
  input  logic              l_req_ready,
  output logic              l_req_we,
  output logic [LA_W-1:0]   l_req_addr,
  output logic [DATA_W-1:0] l_req_wdata,
  input  logic              l_rsp_valid,
  input  logic [DATA_W-1:0] l_rsp_rdata,
  output logic              r_req_valid,
  input  logic              r_req_ready,
  output logic              r_req_we,
  output logic [RA_W-1:0]   r_req_addr,
  output logic [DATA_W-1:0] r_req_wdata,
  input  logic              r_rsp_valid,
  input  logic [DATA_W-1:0] r_rsp_rdata
);

  assign l_req_valid = rq_valid && rq_local;
  assign r_req_valid = rq_valid && !rq_local;
  assign l_req_we    = rq_we;
  assign r_req_we    = rq_we;
  assign l_req_addr  = rq_addr[LA_W-1:0];
  assign r_req_addr  = rq_addr;
  assign l_req_wdata = rq_wdata;
  assign r_req_wdata = rq_wdata;

  assign rq_ready = rq_local ? l_req_ready : r_req_ready;
  // Only one request is ever in flight, so the two responses never collide.
  assign rs_valid = l_rsp_valid || r_rsp_valid;
  assign rs_data  = l_rsp_valid ? l_rsp_rdata : r_rsp_rdata;

endmodule

// File: rtl/sgd_walk_ctrl.sv
module sgd_walk_ctrl
  import sgd_pkg::*;
#(
  parameter int LA_W     = 16,
  parameter int RA_W     = 32,
  parameter int CSZ_W    = 20,
  parameter int DATA_W   = 128,
  parameter int MAX_BLK  = 16384,
  parameter int MAX_LIST = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_take,
  input  logic              cmd_bad,
  input  logic              cmd_put,
  input  logic              cmd_list,
  input  logic [LA_W-1:0]   cmd_laddr,
  input  logic [RA_W-1:0]   cmd_raddr,
  input  logic [CSZ_W-1:0]  cmd_size,
  input  logic [LA_W-1:0]   cmd_lptr,
  input  logic [1:0]        stat_clr,
  output logic              idle,
  output logic              busy,
  output logic              irq,
  output logic              err,
  output logic              elem_abort,
  output logic              rq_valid,
  output logic              rq_local,
  output logic              rq_we,
  output logic [RA_W-1:0]   rq_addr,
  output logic [DATA_W-1:0] rq_wdata,
  input  logic              rq_ready,
  input  logic              rs_valid,
  input  logic [DATA_W-1:0] rs_data
);

  localparam int BEAT_B  = DATA_W / 8;
  localparam int BEAT_SH = $clog2(BEAT_B);
  localparam int SZ_W    = $clog2(MAX_BLK + 1);
  localparam int CNT_W   = $clog2(MAX_LIST + 1);
  localparam logic [LA_W-1:0] L_STEP = LA_W'(BEAT_B);
  localparam logic [RA_W-1:0] R_STEP = RA_W'(BEAT_B);
  localparam logic [SZ_W-1:0] S_STEP = SZ_W'(BEAT_B);

  walk_state_e       state;
  logic              pend;
  logic              put_q;
  logic [LA_W-1:0]   laddr_q;
  logic [RA_W-1:0]   raddr_q;
  logic [LA_W-1:0]   dptr_q;
  logic [SZ_W-1:0]   rem_q;
  logic [CNT_W-1:0]  elems_q;
  logic [DATA_W-1:0] beat_q;

  logic [RA_W-1:0]        d_raddr;
  logic [DESC_SIZE_W-1:0] d_size;
  logic                   d_ok;
  logic                   rsp_here;

  assign d_raddr  = rs_data[RA_W-1:0];
  assign d_size   = rs_data[RA_W +: DESC_SIZE_W];
  assign d_ok     = elem_ok(32'(d_raddr), d_size, BEAT_SH, MAX_BLK);
  assign rsp_here = pend && rs_valid;

  assign idle       = (state == S_IDLE);
  assign busy       = !idle;
  assign elem_abort = (state == S_FETCH_DESC) && rsp_here && !d_ok;

  always_comb begin
    rq_valid = 1'b0;
    rq_local = 1'b1;
    rq_we    = 1'b0;
    rq_addr  = '0;
    rq_wdata = beat_q;
    unique case (state)
      S_FETCH_DESC: begin
        rq_valid = !pend;
        rq_addr  = RA_W'(dptr_q);
      end
      S_READ: begin
        rq_valid = !pend;
        rq_local = put_q;
        rq_addr  = put_q ? RA_W'(laddr_q) : raddr_q;
      end
      S_WRITE: begin
        rq_valid = !pend;
        rq_local = !put_q;
        rq_we    = 1'b1;
        rq_addr  = put_q ? raddr_q : RA_W'(laddr_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pend    <= 1'b0;
      put_q   <= 1'b0;
      laddr_q <= '0;
      raddr_q <= '0;
      dptr_q  <= '0;
      rem_q   <= '0;
      elems_q <= '0;
      beat_q  <= '0;
      irq     <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (stat_clr[0]) irq <= 1'b0;
      if (stat_clr[1]) err <= 1'b0;
      if (rq_valid && rq_ready) pend <= 1'b1;
      if (rsp_here) pend <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_take && cmd_bad) begin
            err <= 1'b1;
          end else if (cmd_take) begin
            put_q   <= cmd_put;
            laddr_q <= cmd_laddr;
            if (cmd_list) begin
              elems_q <= cmd_size[CNT_W-1:0];
              dptr_q  <= cmd_lptr;
              state   <= S_FETCH_DESC;
            end else begin
              elems_q <= '0;
              raddr_q <= cmd_raddr;
              rem_q   <= cmd_size[SZ_W-1:0];
              state   <= (cmd_size == '0) ? S_NEXT : S_READ;
            end
          end
        end
        S_FETCH_DESC: begin
          if (rsp_here) begin
            elems_q <= elems_q - 1'b1;
            dptr_q  <= dptr_q + L_STEP;
            if (!d_ok) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              raddr_q <= d_raddr;
              rem_q   <= d_size[SZ_W-1:0];
              state   <= (d_size == '0) ? S_NEXT : S_READ;
            end
          end
        end
        S_READ: begin
          if (rsp_here) begin
            beat_q <= rs_data;
            state  <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (rsp_here) begin
            laddr_q <= laddr_q + L_STEP;
            raddr_q <= raddr_q + R_STEP;
            rem_q   <= rem_q - S_STEP;
            state   <= (rem_q == S_STEP) ? S_NEXT : S_READ;
          end
        end
        S_NEXT: state <= (elems_q == '0) ? S_DONE : S_FETCH_DESC;
        S_DONE: begin
          irq   <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int LA_W     = 16,
  parameter int RA_W     = 32,
  parameter int CSZ_W    = 20,
  parameter int DATA_W   = 128,
  parameter int MAX_BLK  = 16384,
  parameter int MIN_LIST = 2,
  parameter int MAX_LIST = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_put,
  input  logic              cmd_list,
  input  logic [LA_W-1:0]   cmd_laddr,
  input  logic [RA_W-1:0]   cmd_raddr,
  input  logic [CSZ_W-1:0]  cmd_size,
  input  logic [LA_W-1:0]   cmd_lptr,
  input  logic [1:0]        stat_clr,
  output logic              busy,
  output logic              irq,
  output logic              err,
  output logic              l_req_valid,
  input  logic              l_req_ready,
  output logic              l_req_we,
  output logic [LA_W-1:0]   l_req_addr,
  output logic [DATA_W-1:0] l_req_wdata,
  input  logic              l_rsp_valid,
  input  logic [DATA_W-1:0] l_rsp_rdata,
  output logic              r_req_valid,
  input  logic              r_req_ready,
  output logic              r_req_we,
  output logic [RA_W-1:0]   r_req_addr,
  output logic [DATA_W-1:0] r_req_wdata,
  input  logic              r_rsp_valid,
  input  logic [DATA_W-1:0] r_rsp_rdata
);

  localparam int BEAT_SH = $clog2(DATA_W / 8);

  logic              idle;
  logic              cmd_take;
  logic              cmd_bad;
  logic              cmd_reject;
  logic              elem_abort;
  logic              rq_valid, rq_local, rq_we, rq_ready, rs_valid;
  logic [RA_W-1:0]   rq_addr;
  logic [DATA_W-1:0] rq_wdata, rs_data;

  assign cmd_ready  = idle;
  assign cmd_take   = cmd_valid && idle;
  assign cmd_reject = cmd_take && cmd_bad;

  sgd_cmd_check #(
    .LA_W(LA_W), .RA_W(RA_W), .CSZ_W(CSZ_W), .BEAT_SH(BEAT_SH),
    .MAX_BLK(MAX_BLK), .MIN_LIST(MIN_LIST), .MAX_LIST(MAX_LIST)
  ) u_check (
    .is_list(cmd_list), .laddr(cmd_laddr), .raddr(cmd_raddr),
    .size(cmd_size), .lptr(cmd_lptr), .bad(cmd_bad)
  );

  sgd_walk_ctrl #(
    .LA_W(LA_W), .RA_W(RA_W), .CSZ_W(CSZ_W), .DATA_W(DATA_W),
    .MAX_BLK(MAX_BLK), .MAX_LIST(MAX_LIST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_take(cmd_take), .cmd_bad(cmd_bad), .cmd_put(cmd_put),
    .cmd_list(cmd_list), .cmd_laddr(cmd_laddr), .cmd_raddr(cmd_raddr),
    .cmd_size(cmd_size), .cmd_lptr(cmd_lptr), .stat_clr(stat_clr),
    .idle(idle), .busy(busy), .irq(irq), .err(err), .elem_abort(elem_abort),
    .rq_valid(rq_valid), .rq_local(rq_local), .rq_we(rq_we),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_ready(rq_ready),
    .rs_valid(rs_valid), .rs_data(rs_data)
  );

  sgd_port_route #(
    .LA_W(LA_W), .RA_W(RA_W), .DATA_W(DATA_W)
  ) u_route (
    .rq_valid(rq_valid), .rq_local(rq_local), .rq_we(rq_we),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_ready(rq_ready),
    .rs_valid(rs_valid), .rs_data(rs_data),
    .l_req_valid(l_req_valid), .l_req_ready(l_req_ready), .l_req_we(l_req_we),
    .l_req_addr(l_req_addr), .l_req_wdata(l_req_wdata),
    .l_rsp_valid(l_rsp_valid), .l_rsp_rdata(l_rsp_rdata),
    .r_req_valid(r_req_valid), .r_req_ready(r_req_ready), .r_req_we(r_req_we),
    .r_req_addr(r_req_addr), .r_req_wdata(r_req_wdata),
    .r_rsp_valid(r_rsp_valid), .r_rsp_rdata(r_rsp_rdata)
  );

endmodule

// File: rtl/sgd_checker.sv
module sgd_checker #(
  parameter int LA_W = 16,
  parameter int RA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic [1:0]      stat_clr,
  input logic            busy,
  input logic            irq,
  input logic            err,
  input logic            l_req_valid,
  input logic            l_req_ready,
  input logic [LA_W-1:0] l_req_addr,
  input logic            l_rsp_valid,
  input logic            r_req_valid,
  input logic            r_req_ready,
  input logic [RA_W-1:0] r_req_addr,
  input logic            r_rsp_valid,
  input logic            cmd_reject,
  input logic            elem_abort
);

  logic [1:0] out_cnt;
  logic [1:0] acc_n, rsp_n;
  assign acc_n = {1'b0, l_req_valid && l_req_ready} + {1'b0, r_req_valid && r_req_ready};
  assign rsp_n = {1'b0, l_rsp_valid} + {1'b0, r_rsp_valid};

  always_ff @(posedge clk) begin
    if (!rst_n) out_cnt <= '0;
    else        out_cnt <= out_cnt + acc_n - rsp_n;
  end

  p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= 2'd1);

  p_lhold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    l_req_valid && !l_req_ready |=> l_req_valid && $stable(l_req_addr));

  p_rhold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    r_req_valid && !r_req_ready |=> r_req_valid && $stable(r_req_addr));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !l_req_valid && !r_req_valid);

  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> !busy && err);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    elem_abort |=> !busy && err && !$rose(irq));

  p_irq_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> out_cnt == 2'd0 && !busy);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !stat_clr[0] |=> irq);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err && !stat_clr[1] |=> err);

endmodule

bind sg_dma_engine sgd_checker #(.LA_W(LA_W), .RA_W(RA_W)) u_sgd_checker (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .stat_clr(stat_clr),
  .busy(busy), .irq(irq), .err(err),
  .l_req_valid(l_req_valid), .l_req_ready(l_req_ready), .l_req_addr(l_req_addr),
  .l_rsp_valid(l_rsp_valid),
  .r_req_valid(r_req_valid), .r_req_ready(r_req_ready), .r_req_addr(r_req_addr),
  .r_rsp_valid(r_rsp_valid),
  .cmd_reject(cmd_reject), .elem_abort(elem_abort)
);

// File: tb/test_sg_dma_engine.sv
module test_sg_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int LA_W = 16;
  localparam int RA_W = 32;
  localparam int CSZ_W = 20;
  localparam int DATA_W = 128;
  localparam int LWORDS = 4096;
  localparam int RWORDS = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_put = 1'b0, cmd_list = 1'b0;
  logic [LA_W-1:0] cmd_laddr = '0, cmd_lptr = '0;
  logic [RA_W-1:0] cmd_raddr = '0;
  logic [CSZ_W-1:0] cmd_size = '0;
  logic [1:0] stat_clr = 2'b00;
  logic cmd_ready, busy, irq, err;
  logic l_req_valid, l_req_we, r_req_valid, r_req_we;
  logic l_req_ready, r_req_ready;
  logic [LA_W-1:0] l_req_addr;
  logic [RA_W-1:0] r_req_addr;
  logic [DATA_W-1:0] l_req_wdata, r_req_wdata;
  logic l_rsp_valid = 1'b0, r_rsp_valid = 1'b0;
  logic [DATA_W-1:0] l_rsp_rdata = '0, r_rsp_rdata = '0;

  logic [DATA_W-1:0] lmem [LWORDS];
  logic [DATA_W-1:0] rmem [RWORDS];
  int lreqs = 0, rreqs = 0;
  logic [3:0] stall = 4'd0;
  logic init_go = 1'b0;
  logic dw_en = 1'b0;
  int dw_idx = 0;
  logic [DATA_W-1:0] dw_data = '0;

  int checks = 0, fails = 0, mism = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_dma_engine i_sg_dma_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_put(cmd_put), .cmd_list(cmd_list), .cmd_laddr(cmd_laddr),
    .cmd_raddr(cmd_raddr), .cmd_size(cmd_size), .cmd_lptr(cmd_lptr),
    .stat_clr(stat_clr), .busy(busy), .irq(irq), .err(err),
    .l_req_valid(l_req_valid), .l_req_ready(l_req_ready), .l_req_we(l_req_we),
    .l_req_addr(l_req_addr), .l_req_wdata(l_req_wdata),
    .l_rsp_valid(l_rsp_valid), .l_rsp_rdata(l_rsp_rdata),
    .r_req_valid(r_req_valid), .r_req_ready(r_req_ready), .r_req_we(r_req_we),
    .r_req_addr(r_req_addr), .r_req_wdata(r_req_wdata),
    .r_rsp_valid(r_rsp_valid), .r_rsp_rdata(r_rsp_rdata)
  );

  function automatic logic [DATA_W-1:0] lpat(input int i);
    return {32'hB000_0000 + 32'(i), 32'(i) * 32'd5, 32'h3C3C_3C3C ^ 32'(i), 32'(i)};
  endfunction

  function automatic logic [DATA_W-1:0] rpat(input int i);
    return {32'hA000_0000 + 32'(i), 32'(i) * 32'd3, 32'h5A5A_5A5A ^ 32'(i), 32'(i)};
  endfunction

  function automatic logic [DATA_W-1:0] desc(input int ra, input int sz);
    return {64'd0, 32'(sz), 32'(ra)};
  endfunction

  assign l_req_ready = stall[0] | stall[2];
  assign r_req_ready = stall[1] | ~stall[0];

  // Memory models: one response the cycle after each accepted request.
  always @(posedge clk) begin
    stall <= stall + 4'd3;
    l_rsp_valid <= 1'b0;
    r_rsp_valid <= 1'b0;
    if (init_go) begin
      for (int i = 0; i < LWORDS; i++) lmem[i] <= lpat(i);
      for (int i = 0; i < RWORDS; i++) rmem[i] <= rpat(i);
      lreqs <= 0;
      rreqs <= 0;
    end else if (dw_en) begin
      lmem[dw_idx] <= dw_data;
    end else begin
      if (l_req_valid && l_req_ready) begin
        if (l_req_we) lmem[int'(l_req_addr[15:4])] <= l_req_wdata;
        else l_rsp_rdata <= lmem[int'(l_req_addr[15:4])];
        l_rsp_valid <= 1'b1;
        lreqs <= lreqs + 1;
      end
      if (r_req_valid && r_req_ready) begin
        if (r_req_we) rmem[int'(r_req_addr[14:4])] <= r_req_wdata;
        else r_rsp_rdata <= rmem[int'(r_req_addr[14:4])];
        r_rsp_valid <= 1'b1;
        rreqs <= rreqs + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic init_mems();
    @(negedge clk); init_go = 1'b1;
    @(negedge clk); init_go = 1'b0;
    mism = 0;
  endtask

  task automatic put_desc(input int idx, input int ra, input int sz);
    @(negedge clk); dw_en = 1'b1; dw_idx = idx; dw_data = desc(ra, sz);
    @(negedge clk); dw_en = 1'b0;
  endtask

  task automatic issue(input logic put, input logic lst, input int la, input int ra,
                       input int sz, input int lp);
    @(negedge clk);
    cmd_put = put; cmd_list = lst; cmd_laddr = LA_W'(la); cmd_raddr = RA_W'(ra);
    cmd_size = CSZ_W'(sz); cmd_lptr = LA_W'(lp); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 30000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr = 2'b11;
    @(negedge clk); stat_clr = 2'b00;
  endtask

  // Accumulate mismatches for a segment: dst word li.. from src ri.. of n words.
  task automatic seg_get(input int li, input int ri, input int n);
    for (int k = 0; k < n; k++) if (lmem[li + k] != rpat(ri + k)) mism++;
  endtask

  task automatic seg_put(input int ri, input int li, input int n);
    for (int k = 0; k < n; k++) if (rmem[ri + k] != lpat(li + k)) mism++;
  endtask

  task automatic simple_run(input logic put, input int la, input int ra, input int words);
    string tg;
    tg = put ? "R2" : "R1";
    init_mems();
    issue(put, 1'b0, la, ra, words * 16, 0);
    check(busy && !cmd_ready, "R9 busy after accept", longint'(busy), 1);
    wait_idle();
    check(irq && !err, "R10 irq on completion", longint'(irq), 1);
    if (put) begin
      seg_put(ra / 16, la / 16, words);
      if (rmem[ra / 16 + words] != rpat(ra / 16 + words)) mism++;
    end else begin
      seg_get(la / 16, ra / 16, words);
      if (lmem[la / 16 + words] != lpat(la / 16 + words)) mism++;
    end
    check(mism == 0, {tg, " data"}, mism, 0);
    check(lreqs == words && rreqs == words, {tg, " R7 request count"}, lreqs + rreqs, 2 * words);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R10 irq sticky", longint'(irq), 1);
    check(lreqs + rreqs == 2 * words, "R11 no requests while idle", lreqs + rreqs, 2 * words);
    clear_status();
    check(irq == 1'b0, "R10 irq cleared", longint'(irq), 0);
  endtask

  task automatic expect_reject(input logic lst, input int la, input int ra, input int sz,
                               input int lp, input string tag);
    init_mems();
    issue(1'b0, lst, la, ra, sz, lp);
    check(!busy && err, {tag, " refused"}, longint'(err), 1);
    repeat (4) @(negedge clk);
    check(lreqs == 0 && rreqs == 0 && !irq, {tag, " no traffic"}, lreqs + rreqs, 0);
    clear_status();
    check(!err, "R10 err cleared", longint'(err), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !irq && !err && cmd_ready, "R9 reset state", longint'(busy), 0);
    check(!l_req_valid && !r_req_valid, "R11 reset quiet", longint'(l_req_valid), 0);

    // R1 / R2 sweep over sizes and offsets in both directions
    for (int p = 0; p < 2; p++)
      for (int n = 0; n < 8; n++)
        simple_run(p[0], 16'h8000 + 16 * n, 32'h0400 + 32 * n, n * 3);

    // R3 maximum block accepted, one above refused
    simple_run(1'b0, 16'h8000, 0, 1024);
    expect_reject(1'b0, 16'h8000, 0, 16400, 0, "R3 oversize");
    // R4 misalignment on each field
    expect_reject(1'b0, 16'h8008, 0, 32, 0, "R4 laddr");
    expect_reject(1'b0, 16'h8000, 4, 32, 0, "R4 raddr");
    expect_reject(1'b0, 16'h8000, 0, 24, 0, "R4 size");
    expect_reject(1'b1, 16'h9000, 0, 3, 8, "R4 lptr");
    // R5 list length limits
    expect_reject(1'b1, 16'h9000, 0, 1, 0, "R5 count 1");
    expect_reject(1'b1, 16'h9000, 0, 2049, 0, "R5 count 2049");
    expect_reject(1'b1, 16'h9000, 0, 0, 0, "R5 count 0");

    // R6 / R7 list get with a zero-size element in the middle
    init_mems();
    put_desc(0, 32'h1000, 32);
    put_desc(1, 32'h2000, 0);
    put_desc(2, 32'h3000, 48);
    issue(1'b0, 1'b1, 16'h9000, 0, 3, 0);
    wait_idle();
    seg_get(16'h900, 32'h100, 2);
    seg_get(16'h902, 32'h300, 3);
    if (lmem[16'h905] != lpat(16'h905)) mism++;
    check(mism == 0 && irq, "R6 list get data", mism, 0);
    check(rreqs == 5 && lreqs == 8, "R7 zero element skipped", lreqs + rreqs, 13);
    clear_status();

    // R6 / R5 minimum list, put direction
    init_mems();
    put_desc(0, 32'h0800, 16);
    put_desc(1, 32'h1800, 64);
    issue(1'b1, 1'b1, 16'h9000, 0, 2, 0);
    wait_idle();
    seg_put(32'h80, 16'h900, 1);
    seg_put(32'h180, 16'h901, 4);
    check(mism == 0 && irq && !err, "R6 R5 list put count 2", mism, 0);
    check(rreqs == 5 && lreqs == 7, "R6 list put traffic", lreqs + rreqs, 12);
    clear_status();

    // R5 / R7 maximum list, mostly empty elements
    init_mems();
    for (int i = 0; i < 2048; i++) put_desc(i, (i == 2047) ? 32'h7000 : 0,
                                           (i == 0) ? 16 : ((i == 2047) ? 32 : 0));
    issue(1'b0, 1'b1, 16'h9000, 0, 2048, 0);
    wait_idle();
    seg_get(16'h900, 0, 1);
    seg_get(16'h901, 32'h700, 2);
    check(mism == 0 && irq && !err, "R5 count 2048 data", mism, 0);
    check(rreqs == 3 && lreqs == 2051, "R7 empty elements quiet", lreqs + rreqs, 2054);
    clear_status();

    // R8 bad element aborts the walk
    init_mems();
    put_desc(0, 32'h0100, 16);
    put_desc(1, 32'h0200, 16400);
    put_desc(2, 32'h0300, 16);
    issue(1'b0, 1'b1, 16'h9000, 0, 3, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    check(err && !irq && !busy, "R8 abort flags", longint'(irq), 0);
    seg_get(16'h900, 32'h10, 1);
    if (lmem[16'h901] != lpat(16'h901)) mism++;
    check(mism == 0 && lreqs == 3 && rreqs == 1, "R8 earlier element kept", lreqs + rreqs, 4);
    clear_status();
    // R8 misaligned element address
    init_mems();
    put_desc(0, 32'h0104, 16);
    put_desc(1, 32'h0200, 16);
    issue(1'b1, 1'b1, 16'h9000, 0, 2, 0);
    wait_idle();
    check(err && !irq && rreqs == 0 && lreqs == 1, "R8 misaligned element", rreqs, 0);
    clear_status();

    // R9 command offered while busy is held off
    init_mems();
    issue(1'b0, 1'b0, 16'h8000, 0, 256, 0);
    cmd_put = 1'b1; cmd_size = CSZ_W'(32); cmd_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!cmd_ready, "R9 hold-off ready low", longint'(cmd_ready), 0);
    end
    cmd_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    check(lreqs == 16 && rreqs == 16 && !busy, "R9 second command not taken", lreqs + rreqs, 32);
    check(irq, "R10 irq after held-off run", longint'(irq), 1);
    // R10 clearing only the error bit leaves irq set
    @(negedge clk); stat_clr = 2'b10;
    @(negedge clk); stat_clr = 2'b00;
    check(irq, "R10 irq survives err clear", longint'(irq), 1);
    clear_status();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule